// File: doc/BRIEF.md
# Preloaded Computation Result Table

This block holds a small set of arithmetic computations, each stored as an opcode, two source operands and the result they produce. Software fills the table through a streaming load port before a program starts. After that the contents are fixed: nothing the pipeline does replaces or rewrites an entry. The table is probed at two points in the pipeline. At dispatch, a matching instruction always takes its result from the table and leaves the execution path, so it only waits for in-order commit. At issue, a matching instruction uses the table result only when the stage reports that no functional unit is free. Otherwise it executes normally.

The load port is valid/ready. A beat moves on a rising clock edge where `tbl_wr_valid` and `tbl_wr_ready` are both high. A producer holds its beat stable while ready is low, and ready may stay low indefinitely. Ready is high only while `fill_enable` is high, the table is not sealed and not every entry has been written. Beats fill the entries strictly in order from index 0.

The table becomes sealed on the first clock edge where `fill_enable` is low and at least one entry has been written. Once sealed, it accepts no more beats until `wipe` is asserted. Such a wipe is what a context switch issues.

The probe ports carry no back-pressure, since a pipeline stage cannot stall on a lookup. A probe is taken on every edge where its valid is high. Its response appears in the registered outputs one cycle later.

Top module: `ptab_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both response-valid outputs, both bypass outputs and both result outputs are 0.
- R2: `tbl_wr_ready` is 1 exactly when `fill_enable` is 1, the table is unsealed and fewer than ENTRIES entries are written. Each accepted beat writes the next entry in index order, starting from 0.
- R3: Once sealed, `tbl_wr_ready` stays 0 until a wipe, even with `fill_enable` high again. A beat offered in that state does not change the table contents.
- R4: A probe matches only when its opcode and both source operands all equal those of a written entry. A difference in any one field is a miss.
- R5: An opcode with its most significant bit (bit 5) set is non-arithmetic. Such a probe never matches, even against an entry loaded with the same key.
- R6: A dispatch probe taken on edge t gives, after edge t, `dsp_rsp_valid`=1 and `dsp_bypass` equal to the match outcome. `dsp_result` equals the matched entry's result on a bypass and is 0 otherwise.
- R7: An issue probe gives `iss_bypass`=1 only when it matches and `iss_unit_free` was 0 on the same edge. Otherwise the instruction executes normally: `iss_bypass`=0 and `iss_result`=0.
- R8: Dispatch and issue probes taken on the same edge are resolved independently, each with its own outcome and result.
- R9: When several written entries share a key, the result comes from the lowest-index one.
- R10: A probe taken while `fill_enable` is high misses.
- R11: `wipe` invalidates every entry in one cycle and unseals the table. A probe taken on the same edge as the wipe misses, and so do later probes until the table is loaded again. After the wipe, `tbl_wr_ready` returns once `fill_enable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_enable | input | 1 | Load phase in progress |
| tbl_wr_valid | input | 1 | Load beat valid |
| tbl_wr_ready | output | 1 | Load beat accepted on this edge |
| tbl_wr_opc | input | 6 | Opcode of the loaded entry |
| tbl_wr_src_a | input | 16 | First operand of the loaded entry |
| tbl_wr_src_b | input | 16 | Second operand of the loaded entry |
| tbl_wr_result | input | 16 | Result stored with the entry |
| wipe | input | 1 | Invalidate the whole table (context switch) |
| dsp_valid | input | 1 | Dispatch probe present |
| dsp_opc | input | 6 | Dispatch probe opcode |
| dsp_src_a | input | 16 | Dispatch probe first operand |
| dsp_src_b | input | 16 | Dispatch probe second operand |
| dsp_rsp_valid | output | 1 | Dispatch response present |
| dsp_bypass | output | 1 | Dispatch instruction leaves the execution path |
| dsp_result | output | 16 | Table result for the dispatch probe |
| iss_valid | input | 1 | Issue probe present |
| iss_opc | input | 6 | Issue probe opcode |
| iss_src_a | input | 16 | Issue probe first operand |
| iss_src_b | input | 16 | Issue probe second operand |
| iss_unit_free | input | 1 | A functional unit is free for the issue probe |
| iss_rsp_valid | output | 1 | Issue response present |
| iss_bypass | output | 1 | Issue instruction skips execution |
| iss_result | output | 16 | Table result for the issue probe |

## Verification
The hardest states to reach from the ports are a sealed table that is offered a load beat, and a wipe that coincides with live probes.

The first is reached by wiping and loading only two entries, so that the table is not full. `fill_enable` is then dropped for one cycle and raised again. A beat with a fresh key is offered, and a later probe confirms that the key was never stored.

The second is reached by asserting `wipe` in the same cycle as dispatch and issue probes of a known resident key.

A deliberately duplicated key and a loaded non-arithmetic entry are included in the sweep. These show the lowest-index rule and the class filter at the result outputs.

// File: rtl/ptab_pkg.sv
package ptab_pkg;
  localparam int OPC_W  = 6;
  localparam int OPND_W = 16;
  localparam int RES_W  = 16;
  localparam int CLASS_BIT = OPC_W - 1;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [OPND_W-1:0] src_a;
    logic [OPND_W-1:0] src_b;
  } key_t;

  typedef struct packed {
    key_t             key;
    logic [RES_W-1:0] res;
  } entry_t;

  function automatic logic is_arith(input logic [OPC_W-1:0] opc);
    return !opc[CLASS_BIT];
  endfunction
endpackage

// File: rtl/ptab_store.sv
module ptab_store
  import ptab_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_enable,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  entry_t             wr_entry,
  input  logic               wipe,
  output logic [ENTRIES-1:0] vld,
  output entry_t             tbl [ENTRIES]
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [CNT_W-1:0] fill_cnt;
  logic             sealed;
  logic             full;
  logic             wr_fire;

  assign full     = (fill_cnt == CNT_W'(ENTRIES));
  assign wr_ready = fill_enable && !sealed && !full;
  assign wr_fire  = wr_valid && wr_ready && !wipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      sealed   <= 1'b0;
      vld      <= '0;
    end else if (wipe) begin
      fill_cnt <= '0;
      sealed   <= 1'b0;
      vld      <= '0;
    end else begin
      if (wr_fire) begin
        vld[fill_cnt[IDX_W-1:0]] <= 1'b1;
        fill_cnt                 <= fill_cnt + 1'b1;
      end
      if (!fill_enable && fill_cnt != '0)
        sealed <= 1'b1;
    end
  end

  // Entry payload carries no reset; the valid bits guard every read.
  always_ff @(posedge clk) begin
    if (wr_fire)
      tbl[fill_cnt[IDX_W-1:0]] <= wr_entry;
  end
endmodule

// File: rtl/ptab_match.sv
module ptab_match
  import ptab_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               enable,
  input  key_t               probe_key,
  input  logic [ENTRIES-1:0] vld,
  input  entry_t             tbl [ENTRIES],
  output logic               hit,
  output logic [RES_W-1:0]   hit_res
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = vld[g] && (tbl[g].key == probe_key);
  end

  // Downward scan so the lowest matching index is the one left standing.
  always_comb begin
    hit     = 1'b0;
    hit_res = '0;
    if (enable && is_arith(probe_key.opc)) begin
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (eq[i]) begin
          hit     = 1'b1;
          hit_res = tbl[i].res;
        end
      end
    end
  end
endmodule

// File: rtl/ptab_resp.sv
module ptab_resp
  import ptab_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             probe_valid,
  input  logic             hit,
  input  logic [RES_W-1:0] hit_res,
  input  logic             unit_free,
  output logic             rsp_valid,
  output logic             bypass,
  output logic [RES_W-1:0] result
);
  logic take;
  assign take = probe_valid && hit && !unit_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      bypass    <= 1'b0;
      result    <= '0;
    end else begin
      rsp_valid <= probe_valid;
      bypass    <= take;
      result    <= take ? hit_res : '0;
    end
  end
endmodule

// File: rtl/ptab_top.sv
module ptab_top
  import ptab_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_enable,
  input  logic              tbl_wr_valid,
  output logic              tbl_wr_ready,
  input  logic [OPC_W-1:0]  tbl_wr_opc,
  input  logic [OPND_W-1:0] tbl_wr_src_a,
  input  logic [OPND_W-1:0] tbl_wr_src_b,
  input  logic [RES_W-1:0]  tbl_wr_result,
  input  logic              wipe,
  input  logic              dsp_valid,
  input  logic [OPC_W-1:0]  dsp_opc,
  input  logic [OPND_W-1:0] dsp_src_a,
  input  logic [OPND_W-1:0] dsp_src_b,
  output logic              dsp_rsp_valid,
  output logic              dsp_bypass,
  output logic [RES_W-1:0]  dsp_result,
  input  logic              iss_valid,
  input  logic [OPC_W-1:0]  iss_opc,
  input  logic [OPND_W-1:0] iss_src_a,
  input  logic [OPND_W-1:0] iss_src_b,
  input  logic              iss_unit_free,
  output logic              iss_rsp_valid,
  output logic              iss_bypass,
  output logic [RES_W-1:0]  iss_result
);
  localparam int PORTS = 2;

  entry_t             wr_entry;
  logic [ENTRIES-1:0] vld;
  entry_t             tbl [ENTRIES];
  logic               lookup_en;

  key_t             pkey  [PORTS];
  logic             pval  [PORTS];
  logic             pfree [PORTS];
  logic             phit  [PORTS];
  logic [RES_W-1:0] pres  [PORTS];
  logic             rv    [PORTS];
  logic             byp   [PORTS];
  logic [RES_W-1:0] rres  [PORTS];

  assign wr_entry = '{key: '{opc: tbl_wr_opc, src_a: tbl_wr_src_a, src_b: tbl_wr_src_b},
                      res: tbl_wr_result};
  assign lookup_en = !fill_enable && !wipe;

  // Port 0 is dispatch: treated as having no unit, so every hit bypasses.
  assign pkey[0]  = '{opc: dsp_opc, src_a: dsp_src_a, src_b: dsp_src_b};
  assign pval[0]  = dsp_valid;
  assign pfree[0] = 1'b0;
  assign pkey[1]  = '{opc: iss_opc, src_a: iss_src_a, src_b: iss_src_b};
  assign pval[1]  = iss_valid;
  assign pfree[1] = iss_unit_free;

  ptab_store #(.ENTRIES(ENTRIES)) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_enable(fill_enable),
    .wr_valid   (tbl_wr_valid),
    .wr_ready   (tbl_wr_ready),
    .wr_entry   (wr_entry),
    .wipe       (wipe),
    .vld        (vld),
    .tbl        (tbl)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    ptab_match #(.ENTRIES(ENTRIES)) i_match (
      .enable   (lookup_en),
      .probe_key(pkey[p]),
      .vld      (vld),
      .tbl      (tbl),
      .hit      (phit[p]),
      .hit_res  (pres[p])
    );
    ptab_resp i_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .probe_valid(pval[p]),
      .hit        (phit[p]),
      .hit_res    (pres[p]),
      .unit_free  (pfree[p]),
      .rsp_valid  (rv[p]),
      .bypass     (byp[p]),
      .result     (rres[p])
    );
  end

  assign dsp_rsp_valid = rv[0];
  assign dsp_bypass    = byp[0];
  assign dsp_result    = rres[0];
  assign iss_rsp_valid = rv[1];
  assign iss_bypass    = byp[1];
  assign iss_result    = rres[1];
endmodule

// File: rtl/ptab_checker.sv
module ptab_checker
  import ptab_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fill_enable,
  input logic             tbl_wr_ready,
  input logic             wipe,
  input logic [OPC_W-1:0] dsp_opc,
  input logic [OPC_W-1:0] iss_opc,
  input logic             iss_unit_free,
  input logic             dsp_rsp_valid,
  input logic             dsp_bypass,
  input logic             iss_rsp_valid,
  input logic             iss_bypass
);
  assert_bypass_has_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_bypass |-> dsp_rsp_valid) and (iss_bypass |-> iss_rsp_valid));

  assert_issue_unit_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_bypass |-> $past(!iss_unit_free));

  assert_class_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_rsp_valid && $past(dsp_opc[CLASS_BIT])) |-> !dsp_bypass);

  assert_class_filter_iss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_rsp_valid && $past(iss_opc[CLASS_BIT])) |-> !iss_bypass);

  assert_fill_phase_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_enable) |-> (!dsp_bypass && !iss_bypass));

  assert_wipe_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wipe) |-> (!dsp_bypass && !iss_bypass));

  assert_sealed_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_enable) && !$past(tbl_wr_ready) && !$past(wipe) && fill_enable)
      |-> !tbl_wr_ready);
endmodule

bind ptab_top ptab_checker i_chk (.*);

// File: tb/test_ptab_top.sv
module test_ptab_top;
  import ptab_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fill_enable = 1'b0;
  logic              tbl_wr_valid = 1'b0;
  logic              tbl_wr_ready;
  logic [OPC_W-1:0]  tbl_wr_opc = '0;
  logic [OPND_W-1:0] tbl_wr_src_a = '0;
  logic [OPND_W-1:0] tbl_wr_src_b = '0;
  logic [RES_W-1:0]  tbl_wr_result = '0;
  logic              wipe = 1'b0;
  logic              dsp_valid = 1'b0;
  logic [OPC_W-1:0]  dsp_opc = '0;
  logic [OPND_W-1:0] dsp_src_a = '0;
  logic [OPND_W-1:0] dsp_src_b = '0;
  logic              dsp_rsp_valid, dsp_bypass;
  logic [RES_W-1:0]  dsp_result;
  logic              iss_valid = 1'b0;
  logic [OPC_W-1:0]  iss_opc = '0;
  logic [OPND_W-1:0] iss_src_a = '0;
  logic [OPND_W-1:0] iss_src_b = '0;
  logic              iss_unit_free = 1'b0;
  logic              iss_rsp_valid, iss_bypass;
  logic [RES_W-1:0]  iss_result;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  key_t             m_key [N];
  logic [RES_W-1:0] m_res [N];
  bit               m_vld [N];
  int               m_fill = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptab_top #(.ENTRIES(N)) i_ptab_top (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic key_t mk(input int opc, input int a, input int b);
    return '{opc: OPC_W'(opc), src_a: OPND_W'(a), src_b: OPND_W'(b)};
  endfunction

  // Reference lookup: lowest written index with an equal key, arithmetic only.
  task automatic ref_lookup(input key_t k, output bit hit, output logic [RES_W-1:0] res);
    hit = 0;
    res = '0;
    if (k.opc[OPC_W-1] == 1'b0)
      for (int i = N - 1; i >= 0; i--)
        if (m_vld[i] && m_key[i] == k) begin
          hit = 1;
          res = m_res[i];
        end
  endtask

  task automatic load_beat(input key_t k, input logic [RES_W-1:0] r);
    tbl_wr_valid  = 1'b1;
    tbl_wr_opc    = k.opc;
    tbl_wr_src_a  = k.src_a;
    tbl_wr_src_b  = k.src_b;
    tbl_wr_result = r;
    while (!tbl_wr_ready) @(negedge clk);
    m_key[m_fill] = k;
    m_res[m_fill] = r;
    m_vld[m_fill] = 1;
    m_fill++;
    @(negedge clk);
    tbl_wr_valid = 1'b0;
  endtask

  // Drive both probes for one edge, then compare with the reference.
  task automatic probe(input key_t dk, input key_t ik, input logic free, input string tag);
    bit dh, ih;
    logic [RES_W-1:0] dr, ir;
    ref_lookup(dk, dh, dr);
    ref_lookup(ik, ih, ir);
    if (fill_enable || wipe) begin dh = 0; ih = 0; dr = '0; ir = '0; end
    if (free) begin ih = 0; ir = '0; end
    dsp_valid = 1'b1; dsp_opc = dk.opc; dsp_src_a = dk.src_a; dsp_src_b = dk.src_b;
    iss_valid = 1'b1; iss_opc = ik.opc; iss_src_a = ik.src_a; iss_src_b = ik.src_b;
    iss_unit_free = free;
    @(negedge clk);
    dsp_valid = 1'b0;
    iss_valid = 1'b0;
    chk({tag, " R6 dsp_rsp_valid"}, 32'(dsp_rsp_valid), 32'd1);
    chk({tag, " R6 dsp_bypass"}, 32'(dsp_bypass), 32'(dh));
    chk({tag, " R6 dsp_result"}, 32'(dsp_result), 32'(dr));
    chk({tag, " R7 R8 iss_bypass"}, 32'(iss_bypass), 32'(ih));
    chk({tag, " R7 R8 iss_result"}, 32'(iss_result), 32'(ir));
  endtask

  function automatic key_t sweep_key(input int i);
    case (i)
      5: return mk(6'h21, 7, 8);
      6: return mk(3, 7, 12);
      7: return mk(9, 16'hFFFF, 16'hFFFF);
      default: return mk(i + 1, i * 3 + 1, i * 5 + 2);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 dsp_rsp_valid in reset", 32'(dsp_rsp_valid), 32'd0);
    chk("R1 iss_bypass in reset", 32'(iss_bypass), 32'd0);
    chk("R1 results in reset", 32'(dsp_result) | 32'(iss_result), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dsp_bypass after reset", 32'(dsp_bypass), 32'd0);
    chk("R1 iss_rsp_valid after reset", 32'(iss_rsp_valid), 32'd0);

    fill_enable = 1'b1;
    #1;
    chk("R2 ready with fill_enable", 32'(tbl_wr_ready), 32'd1);
    for (int i = 0; i < N; i++) begin
      load_beat(sweep_key(i), RES_W'(16'hA000 + i * 17));
      if (i == 0) probe(sweep_key(0), sweep_key(0), 1'b0, "R10 fill-phase");
    end
    #1;
    chk("R2 ready low when full", 32'(tbl_wr_ready), 32'd0);
    fill_enable = 1'b0;
    @(negedge clk);

    // Sweep every entry on both ports; entry 6 repeats entry 2 (R9), entry 5 is non-arithmetic (R5).
    for (int i = 0; i < N; i++)
      for (int f = 0; f < 2; f++)
        probe(sweep_key(i), sweep_key(N - 1 - i), f[0], "R4 R5 R9 sweep");
    probe(mk(3, 7, 12), mk(3, 7, 12), 1'b0, "R9 duplicate");
    chk("R9 lowest index result", 32'(dsp_result), 32'h0000A022);
    probe(mk(6'h21, 7, 8), mk(6'h21, 7, 8), 1'b0, "R5 non-arith");
    chk("R5 non-arith miss", 32'(dsp_bypass), 32'd0);

    // Single-field near misses.
    for (int i = 0; i < 5; i++) begin
      key_t k = sweep_key(i);
      for (int v = 0; v < 3; v++) begin
        key_t m = k;
        if (v == 0) m.opc = m.opc ^ 6'h02;
        if (v == 1) m.src_a = m.src_a + 1'b1;
        if (v == 2) m.src_b = m.src_b ^ 16'h8000;
        probe(m, k, 1'b1, "R4 near miss");
        chk("R4 near miss dsp", 32'(dsp_bypass), 32'd0);
        chk("R7 unit free no bypass", 32'(iss_bypass), 32'd0);
      end
    end

    // Wipe coinciding with resident-key probes.
    wipe = 1'b1;
    probe(sweep_key(0), sweep_key(1), 1'b0, "R11 wipe cycle");
    wipe = 1'b0;
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_fill = 0;
    probe(sweep_key(0), sweep_key(1), 1'b0, "R11 after wipe");
    chk("R11 miss after wipe", 32'(dsp_bypass), 32'd0);
    fill_enable = 1'b1;
    #1;
    chk("R11 ready returns", 32'(tbl_wr_ready), 32'd1);
    load_beat(sweep_key(0), 16'h1234);
    load_beat(sweep_key(1), 16'h5678);
    fill_enable = 1'b0;
    @(negedge clk);
    fill_enable = 1'b1;
    #1;
    chk("R3 sealed ready low", 32'(tbl_wr_ready), 32'd0);
    tbl_wr_valid = 1'b1;
    tbl_wr_opc = 6'd2; tbl_wr_src_a = 16'd99; tbl_wr_src_b = 16'd98; tbl_wr_result = 16'hBEEF;
    repeat (2) @(negedge clk);
    chk("R3 sealed stays low", 32'(tbl_wr_ready), 32'd0);
    tbl_wr_valid = 1'b0;
    fill_enable = 1'b0;
    @(negedge clk);
    probe(mk(2, 99, 98), sweep_key(0), 1'b0, "R3 rejected beat");
    chk("R3 rejected key absent", 32'(dsp_bypass), 32'd0);
    chk("R11 reload result", 32'(iss_result), 32'h1234);
    probe(sweep_key(1), sweep_key(1), 1'b0, "R8 same key both ports");
    chk("R8 dsp result", 32'(dsp_result), 32'h5678);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule